// File: doc/BRIEF.md
# Byte-Reversing Store Unit

This block is the store datapath behind two byte-reversing store operations, one halfword-sized and one word-sized. For each accepted request it takes a base address, a signed 12-bit displacement, a source register value and a size select. It forms the effective address by sign-extending the displacement and scaling it by the access size. It reverses the byte order of the source data, places the result on the right byte lanes of a 32-bit write port, and raises a write strobe that stays asserted until the memory side signals ready.

A request is taken on any clock edge where `in_valid` and `in_ready` are both high. The address, data, byte enables and strobe are registered, so they appear the cycle after acceptance. If the effective address is not aligned to the access size, no write is issued. Instead a one-cycle fault pulse appears and the byte enables read zero. A new request can be taken on the same edge that retires the pending write, so stores can run back to back.

Top module: `bswap_store_unit`

## Requirements
- R1: A halfword store (`in_size` = 0) writes `{src[7:0], src[15:8]}` into both 16-bit halves of `mem_wdata`.
- R2: A word store (`in_size` = 1) writes `mem_wdata = {src[7:0], src[15:8], src[23:16], src[31:24]}`.
- R3: For a halfword store, `mem_addr` equals base plus the sign-extended 12-bit displacement shifted left by 1, modulo 2^32.
- R4: For a word store, `mem_addr` equals base plus the sign-extended 12-bit displacement shifted left by 2, modulo 2^32.
- R5: An aligned halfword store drives `mem_be` = 4'b0011 when address bit 1 is 0, and 4'b1100 when it is 1.
- R6: An aligned word store drives `mem_be` = 4'b1111.
- R7: A halfword address with bit 0 set, or a word address with bits 1:0 nonzero, produces `fault` high for exactly one cycle after acceptance. In that cycle `mem_we` is 0, `mem_be` is 0 and `mem_addr` shows the faulting address.
- R8: While `mem_we` is high and `mem_ready` is low, `in_ready` is low, new requests are ignored, and address, data, enables and strobe hold their values. The strobe drops the cycle after `mem_ready` is seen high.
- R9: When `mem_ready` is high with a write pending, a request presented in the same cycle is accepted. The next cycle shows the new request's address, data and strobe.
- R10: After synchronous reset, `mem_we`, `fault` and `mem_be` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Store request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_size | input | 1 | 0 = halfword, 1 = word |
| in_base | input | 32 | Base address |
| in_disp | input | 12 | Signed displacement in access units |
| in_src | input | 32 | Source data |
| mem_ready | input | 1 | Memory takes the pending write |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Byte-reversed write data |
| mem_be | output | 4 | Byte enables |
| fault | output | 1 | Misalignment pulse |

## Verification
Two events can share a cycle here: the pending write retiring under `mem_ready`, and a new request being accepted. The bench triggers this by raising `mem_ready` and `in_valid` on the same negative edge while a write is held. It then checks that the following cycle carries the new request's address, data and strobe with no gap. After that it confirms that the strobe drops once the new write is also taken.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  typedef enum logic {
    SZ_HALF = 1'b0,
    SZ_WORD = 1'b1
  } st_size_e;
endpackage

// File: rtl/bswap_ea.sv
module bswap_ea #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [DISP_W-1:0]   disp,
  input  bswap_pkg::st_size_e size,
  output logic [ADDR_W-1:0]   ea
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] disp_scaled;

  // sign extension to the address width, then scale by access size
  assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    if (size == bswap_pkg::SZ_WORD) disp_scaled = disp_sx << 2;
    else                            disp_scaled = disp_sx << 1;
  end

  assign ea = base + disp_scaled;
endmodule

// File: rtl/bswap_reorder.sv
module bswap_reorder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   src,
  input  bswap_pkg::st_size_e size,
  output logic [DATA_W-1:0]   dout
);
  localparam int NB = DATA_W / 8;
  localparam int NH = NB / 2;

  logic [DATA_W-1:0] rev_word;
  logic [DATA_W-1:0] rev_half;

  // full reversal: lane i gets source lane NB-1-i
  for (genvar i = 0; i < NB; i++) begin : g_word
    assign rev_word[i*8 +: 8] = src[(NB-1-i)*8 +: 8];
  end

  // halfword reversal replicated on every halfword lane
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign rev_half[h*16 +: 16] = {src[7:0], src[15:8]};
  end

  assign dout = (size == bswap_pkg::SZ_WORD) ? rev_word : rev_half;
endmodule

// File: rtl/bswap_lanes.sv
module bswap_lanes #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] ea_lo,
  input  bswap_pkg::st_size_e         size,
  output logic [DATA_W/8-1:0]         be,
  output logic                        misaligned
);
  localparam int NB = DATA_W / 8;
  localparam int LB = $clog2(NB);

  logic [DATA_W/8-1:0] be_half;

  // halfword lane h covers bytes 2h and 2h+1
  for (genvar i = 0; i < NB; i++) begin : g_be
    assign be_half[i] = (ea_lo[LB-1:1] == (LB-1)'(i / 2));
  end

  always_comb begin
    if (size == bswap_pkg::SZ_WORD) begin
      be         = '1;
      misaligned = |ea_lo;
    end else begin
      be         = be_half;
      misaligned = ea_lo[0];
    end
  end
endmodule

// File: rtl/bswap_store_unit.sv
module bswap_store_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_size,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic [DISP_W-1:0]   in_disp,
  input  logic [DATA_W-1:0]   in_src,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  output logic                fault
);
  localparam int NB = DATA_W / 8;
  localparam int LB = $clog2(NB);

  bswap_pkg::st_size_e size_e;
  logic [ADDR_W-1:0]   ea;
  logic [DATA_W-1:0]   rdata;
  logic [NB-1:0]       be_c;
  logic                misal;
  logic                accept;

  assign size_e = bswap_pkg::st_size_e'(in_size);

  bswap_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
    .base (in_base),
    .disp (in_disp),
    .size (size_e),
    .ea   (ea)
  );

  bswap_reorder #(.DATA_W(DATA_W)) u_reorder (
    .src  (in_src),
    .size (size_e),
    .dout (rdata)
  );

  bswap_lanes #(.DATA_W(DATA_W)) u_lanes (
    .ea_lo      (ea[LB-1:0]),
    .size       (size_e),
    .be         (be_c),
    .misaligned (misal)
  );

  // a new request may enter as the held write retires
  assign in_ready = !mem_we || mem_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      fault     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      fault <= accept && misal;
      if (accept) begin
        mem_addr  <= ea;
        mem_wdata <= rdata;
        mem_be    <= misal ? '0 : be_c;
        mem_we    <= !misal;
      end else if (mem_ready) begin
        mem_we <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bswap_store_chk.sv
module bswap_store_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                mem_ready,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                fault
);
  localparam int NB = DATA_W / 8;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) &&
                                $stable(mem_wdata) && $stable(mem_be)));

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |-> !in_ready);

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_we && mem_be == '0));

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !fault);

  p_be_shape_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 2 || $countones(mem_be) == NB));

  p_half_align_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $countones(mem_be) == 2) |-> !mem_addr[0]);

  p_word_align_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $countones(mem_be) == NB) |-> (mem_addr[1:0] == 2'b00));

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && !fault && in_ready));
endmodule

bind bswap_store_unit bswap_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .fault     (fault)
);

// File: tb/tb_bswap_store_unit.sv
module tb_bswap_store_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_size = 1'b0;
  logic [31:0] in_base = '0;
  logic [11:0] in_disp = '0;
  logic [31:0] in_src = '0;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bswap_store_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_base(in_base), .in_disp(in_disp), .in_src(in_src),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .fault(fault)
  );

  // {size, base, disp, src, exp_addr, exp_be, exp_fault}
  localparam logic [113:0] VEC [8] = '{
    {1'b0, 32'h00001000, 12'h004, 32'hAABB1122, 32'h00001008, 4'h3, 1'b0},
    {1'b0, 32'h00001000, 12'hFFF, 32'h0000BEEF, 32'h00000FFE, 4'hC, 1'b0},
    {1'b1, 32'h00002000, 12'h003, 32'h11223344, 32'h0000200C, 4'hF, 1'b0},
    {1'b1, 32'h00002000, 12'h800, 32'hDEADBEEF, 32'h00000000, 4'hF, 1'b0},
    {1'b0, 32'h00003001, 12'h000, 32'h12345678, 32'h00003001, 4'h0, 1'b1},
    {1'b1, 32'h00004002, 12'h001, 32'h12345678, 32'h00004006, 4'h0, 1'b1},
    {1'b0, 32'h00000000, 12'h7FF, 32'h12345678, 32'h00000FFE, 4'hC, 1'b0},
    {1'b1, 32'hFFFFFFFC, 12'h001, 32'hCAFEF00D, 32'h00000000, 4'hF, 1'b0}
  };

  function automatic logic [31:0] model_data(input logic sz, input logic [31:0] s);
    if (sz) return {s[7:0], s[15:8], s[23:16], s[31:24]};
    return {s[7:0], s[15:8], s[7:0], s[15:8]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic sz, input logic [31:0] b, input logic [11:0] d,
                       input logic [31:0] s);
    @(negedge clk);
    in_size = sz; in_base = b; in_disp = d; in_src = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 mem_we", {31'd0, mem_we}, 32'd0);
    check("R10 fault", {31'd0, fault}, 32'd0);
    check("R10 mem_be", {28'd0, mem_be}, 32'd0);
    check("R10 in_ready", {31'd0, in_ready}, 32'd1);

    for (int v = 0; v < 8; v++) begin
      logic        sz;
      logic [31:0] b, s, ea;
      logic [11:0] d;
      logic [3:0]  be;
      logic        f;
      {sz, b, d, s, ea, be, f} = VEC[v];
      mem_ready = 1'b0;
      issue(sz, b, d, s);
      check(sz ? "R4 address" : "R3 address", mem_addr, ea);
      check(sz ? "R6 enables" : "R5 enables", {28'd0, mem_be}, {28'd0, be});
      check("R7 fault", {31'd0, fault}, {31'd0, f});
      check("R7 strobe", {31'd0, mem_we}, {31'd0, !f});
      if (!f) begin
        check(sz ? "R2 data" : "R1 data", mem_wdata, model_data(sz, s));
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        check("R8 release", {31'd0, mem_we}, 32'd0);
      end else begin
        @(negedge clk);
        check("R7 pulse end", {31'd0, fault}, 32'd0);
      end
    end

    // R8 hold under stall, competing request ignored
    issue(1'b1, 32'h00006000, 12'h002, 32'h01020304);
    check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    in_size = 1'b0; in_base = 32'h00007000; in_disp = 12'h001;
    in_src = 32'h0000FFEE; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R8 addr held", mem_addr, 32'h00006008);
    check("R8 data held", mem_wdata, 32'h04030201);
    check("R8 be held", {28'd0, mem_be}, 32'hF);
    check("R8 strobe held", {31'd0, mem_we}, 32'd1);

    // R9 retire and accept on the same edge
    mem_ready = 1'b1;
    in_size = 1'b0; in_base = 32'h00005000; in_disp = 12'h001;
    in_src = 32'h0000A55A; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 addr", mem_addr, 32'h00005002);
    check("R9 data", mem_wdata, 32'h5AA55AA5);
    check("R9 be", {28'd0, mem_be}, 32'hC);
    check("R9 strobe", {31'd0, mem_we}, 32'd1);
    @(negedge clk);
    mem_ready = 1'b0;
    check("R9 drain", {31'd0, mem_we}, 32'd0);

    // R7 misaligned request arriving as a write retires
    issue(1'b1, 32'h00008000, 12'h000, 32'h0BADF00D);
    mem_ready = 1'b1;
    in_size = 1'b1; in_base = 32'h00008003; in_disp = 12'h000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; mem_ready = 1'b0;
    check("R7 fault on retire", {31'd0, fault}, 32'd1);
    check("R7 no strobe on retire", {31'd0, mem_we}, 32'd0);
    check("R7 fault addr", mem_addr, 32'h00008003);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule